// File: doc/BRIEF.md
# Dual Page-Size Address Translation Buffer

This block turns a 32-bit linear address into a physical address by searching two mapping stores in the same cycle. One store holds 4 KB mappings in a 32-set, 4-way set-associative array (128 entries). The other holds 4 MB mappings in a 4-entry fully associative array. Every entry carries a user-permission bit, a write-permission bit and a global bit next to its physical frame. Each lookup is checked against these bits and answers hit, miss or fault one cycle later.

Three maintenance operations change the contents. A full flush models a reload of the page-directory base. An invalidate removes the mapping that covers one linear page. A fill installs one mapping that was fetched by an external page walker. Walking the tables, cache interaction and exception delivery are handled elsewhere. This block only reports what it found.

Top module: `dual_tlb`

## Requirements
- R1: After reset every entry in both stores is invalid, all response outputs are 0, and every lookup misses until a fill takes place.
- R2: A lookup presented with `lk_valid` high is answered on the next cycle with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. When no lookup was presented, all response outputs are 0.
- R3: For 4 KB mappings, linear bits 16:12 choose the set and bits 31:17 are the tag. On a hit `rsp_paddr` = {frame[19:0], linear[11:0]}.
- R4: For 4 MB mappings, linear bits 31:22 are compared against each of the 4 entries. On a hit `rsp_paddr` = {frame[19:10], linear[21:0]}, and frame bits 9:0 are ignored.
- R5: Both stores are searched for every lookup. When both match, the 4 MB translation is returned and `rsp_multi` is 1. Otherwise `rsp_multi` is 0.
- R6: A matching entry gives a fault instead of a hit in two cases: the access is from user mode (`lk_user`=1) and the entry's user bit is 0, or the access is a write (`lk_write`=1) and the entry's write bit is 0. A supervisor read never faults.
- R7: A full flush clears every entry in both stores. When `glob_en` is 1 during the flush, entries stored with the global bit set survive.
- R8: An invalidate clears the 4 KB entry whose set and tag match `inv_page`, and also any 4 MB entry whose bits 31:22 match. The global bit does not protect an entry from this. All other entries are left as they were.
- R9: A fill chooses its slot in this order: a valid slot that already maps the same page is overwritten, otherwise the lowest-numbered invalid slot is used, otherwise a slot picked by a free-running 8-bit LFSR. Filling a full set or a full 4 MB store therefore evicts exactly one older mapping.
- R10: When operations coincide in one cycle, a flush takes precedence over an invalidate and an invalidate over a fill, and the lower-priority operation is dropped. A lookup in the same cycle as any of these sees the contents from before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Linear address to translate |
| lk_user | input | 1 | Access is from user mode |
| lk_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No mapping in either store |
| rsp_fault | output | 1 | Mapping found but the access is denied |
| rsp_multi | output | 1 | Both stores matched |
| rsp_paddr | output | 32 | Physical address when the lookup hits or faults |
| flush_all | input | 1 | Full flush |
| glob_en | input | 1 | Keep global entries during a flush |
| inv_valid | input | 1 | Invalidate request |
| inv_page | input | 20 | Linear page (bits 31:12) to invalidate |
| fill_valid | input | 1 | Fill request |
| fill_big | input | 1 | Fill targets the 4 MB store |
| fill_page | input | 20 | Linear page (bits 31:12) of the mapping |
| fill_frame | input | 20 | Physical frame (bits 31:12) |
| fill_user | input | 1 | Mapping allows user-mode access |
| fill_wr | input | 1 | Mapping allows writes |
| fill_glob | input | 1 | Mapping is global |

## Verification
A stale valid bit, a wrong tag or a misplaced frame inside either store shows up at the ports as a wrong hit, miss or physical address. It appears on the cycle after the first lookup that touches that set or entry. A flush or invalidate that leaves something behind shows up the same way at the next probe of the page concerned. A victim choice that evicts two mappings, or none, shows up when the older pages in that set are probed right after the overflowing fill. Permission and priority errors show up as a fault where a hit was expected, or the reverse, on the cycle after the lookup.

// File: rtl/dual_tlb.sv
`timescale 1ns/1ps
module dual_tlb #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  parameter int LWAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_user,
  input  logic        lk_write,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_miss,
  output logic        rsp_fault,
  output logic        rsp_multi,
  output logic [31:0] rsp_paddr,
  input  logic        flush_all,
  input  logic        glob_en,
  input  logic        inv_valid,
  input  logic [31:12] inv_page,
  input  logic        fill_valid,
  input  logic        fill_big,
  input  logic [31:12] fill_page,
  input  logic [19:0] fill_frame,
  input  logic        fill_user,
  input  logic        fill_wr,
  input  logic        fill_glob
);
  localparam int SIDX = $clog2(SETS);
  localparam int TAGW = 20 - SIDX;
  localparam int WIDX = $clog2(WAYS);
  localparam int LIDX = $clog2(LWAYS);

  logic            s_val [SETS][WAYS];
  logic [TAGW-1:0] s_tag [SETS][WAYS];
  logic [19:0]     s_frm [SETS][WAYS];
  logic            s_usr [SETS][WAYS];
  logic            s_wr  [SETS][WAYS];
  logic            s_glb [SETS][WAYS];
  logic            l_val [LWAYS];
  logic [9:0]      l_tag [LWAYS];
  logic [9:0]      l_frm [LWAYS];
  logic            l_usr [LWAYS];
  logic            l_wr  [LWAYS];
  logic            l_glb [LWAYS];
  logic [7:0]      lfsr;

  wire [SIDX-1:0] lk_set = lk_addr[12 +: SIDX];
  wire [TAGW-1:0] lk_tag = lk_addr[31 -: TAGW];
  wire [SIDX-1:0] i_set  = inv_page[12 +: SIDX];
  wire [TAGW-1:0] i_tag  = inv_page[31 -: TAGW];
  wire [SIDX-1:0] f_set  = fill_page[12 +: SIDX];
  wire [TAGW-1:0] f_tag  = fill_page[31 -: TAGW];
  wire do_inv  = inv_valid & ~flush_all;
  wire do_fill = fill_valid & ~flush_all & ~inv_valid;

  // lookup: both stores in parallel
  logic [WAYS-1:0] s_mvec;
  logic [WIDX-1:0] s_way;
  logic [LIDX-1:0] l_idx;
  logic            l_hit;
  always_comb begin
    s_mvec = '0; s_way = '0; l_hit = 1'b0; l_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (s_val[lk_set][w] && s_tag[lk_set][w] == lk_tag) begin
        s_mvec[w] = 1'b1; s_way = WIDX'(w);
      end
    for (int e = 0; e < LWAYS; e++)
      if (l_val[e] && l_tag[e] == lk_addr[31:22]) begin
        l_hit = 1'b1; l_idx = LIDX'(e);
      end
  end
  wire        s_hit   = |s_mvec;
  wire        hit_any = s_hit | l_hit;
  wire        p_usr   = l_hit ? l_usr[l_idx] : s_usr[lk_set][s_way];
  wire        p_wr    = l_hit ? l_wr[l_idx]  : s_wr[lk_set][s_way];
  wire        deny    = (lk_user & ~p_usr) | (lk_write & ~p_wr);
  wire [31:0] paddr   = l_hit ? {l_frm[l_idx], lk_addr[21:0]}
                              : {s_frm[lk_set][s_way], lk_addr[11:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_fault <= 1'b0; rsp_multi <= 1'b0; rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & hit_any & ~deny;
      rsp_fault <= lk_valid & hit_any & deny;
      rsp_miss  <= lk_valid & ~hit_any;
      rsp_multi <= lk_valid & s_hit & l_hit;
      rsp_paddr <= (lk_valid & hit_any) ? paddr : '0;
    end
  end

  // fill slot: same page, then lowest invalid, then LFSR
  logic [WIDX-1:0] s_pick;
  logic [LIDX-1:0] l_pick;
  always_comb begin
    s_pick = lfsr[WIDX-1:0];
    l_pick = lfsr[LIDX-1:0];
    for (int w = WAYS-1; w >= 0; w--)
      if (!s_val[f_set][w]) s_pick = WIDX'(w);
    for (int w = 0; w < WAYS; w++)
      if (s_val[f_set][w] && s_tag[f_set][w] == f_tag) s_pick = WIDX'(w);
    for (int e = LWAYS-1; e >= 0; e--)
      if (!l_val[e]) l_pick = LIDX'(e);
    for (int e = 0; e < LWAYS; e++)
      if (l_val[e] && l_tag[e] == fill_page[31:22]) l_pick = LIDX'(e);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 8'h01;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) s_val[s][w] <= 1'b0;
      for (int e = 0; e < LWAYS; e++) l_val[e] <= 1'b0;
    end else if (flush_all) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (!(glob_en && s_glb[s][w])) s_val[s][w] <= 1'b0;
      for (int e = 0; e < LWAYS; e++)
        if (!(glob_en && l_glb[e])) l_val[e] <= 1'b0;
    end else if (inv_valid) begin
      for (int w = 0; w < WAYS; w++)
        if (s_tag[i_set][w] == i_tag) s_val[i_set][w] <= 1'b0;
      for (int e = 0; e < LWAYS; e++)
        if (l_tag[e] == inv_page[31:22]) l_val[e] <= 1'b0;
    end else if (fill_valid) begin
      if (fill_big) l_val[l_pick] <= 1'b1;
      else          s_val[f_set][s_pick] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill && fill_big) begin
      l_tag[l_pick] <= fill_page[31:22];
      l_frm[l_pick] <= fill_frame[19:10];
      l_usr[l_pick] <= fill_user;
      l_wr[l_pick]  <= fill_wr;
      l_glb[l_pick] <= fill_glob;
    end else if (do_fill) begin
      s_tag[f_set][s_pick] <= f_tag;
      s_frm[f_set][s_pick] <= fill_frame;
      s_usr[f_set][s_pick] <= fill_user;
      s_wr[f_set][s_pick]  <= fill_wr;
      s_glb[f_set][s_pick] <= fill_glob;
    end
  end

  // checker views
  logic any_valid, inv_match;
  always_comb begin
    any_valid = 1'b0; inv_match = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) any_valid |= s_val[s][w];
    for (int e = 0; e < LWAYS; e++) begin
      any_valid |= l_val[e];
      inv_match |= l_val[e] && l_tag[e] == inv_page[31:22];
    end
    for (int w = 0; w < WAYS; w++)
      inv_match |= s_val[i_set][w] && s_tag[i_set][w] == i_tag;
  end

  assert_reply_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  assert_multi_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> !rsp_miss);
  assert_sup_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_user && !lk_write |=> !rsp_fault);
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all && !glob_en |=> !any_valid);
  assert_inv_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_inv |=> !inv_match);
  assert_single_way_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_mvec));
endmodule

// File: tb/dual_tlb_tb.sv
`timescale 1ns/1ps
module dual_tlb_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, lk_valid, lk_user, lk_write;
  logic [31:0] lk_addr;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi;
  logic [31:0] rsp_paddr;
  logic flush_all, glob_en, inv_valid, fill_valid, fill_big, fill_user, fill_wr, fill_glob;
  logic [31:12] inv_page, fill_page;
  logic [19:0] fill_frame;

  dual_tlb u_dut (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_user(lk_user), .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr),
    .flush_all(flush_all), .glob_en(glob_en), .inv_valid(inv_valid), .inv_page(inv_page),
    .fill_valid(fill_valid), .fill_big(fill_big), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_user(fill_user), .fill_wr(fill_wr), .fill_glob(fill_glob));

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model: a flat pool of mappings
  bit          m_v [64];
  bit          m_big [64];
  logic [31:0] m_a [64];
  logic [19:0] m_f [64];
  bit          m_u [64], m_w [64], m_g [64];

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit same(int i, bit big, logic [31:0] a);
    if (!m_v[i] || m_big[i] != big) return 0;
    return big ? (m_a[i][31:22] == a[31:22]) : (m_a[i][31:12] == a[31:12]);
  endfunction

  function automatic int find(bit big, logic [31:0] a);
    for (int i = 0; i < 64; i++) if (same(i, big, a)) return i;
    return -1;
  endfunction

  function automatic bit bucket(int i, bit big, logic [31:0] a);
    if (!m_v[i] || m_big[i] != big) return 0;
    return big ? 1'b1 : (m_a[i][16:12] == a[16:12]);
  endfunction

  // response-valid compared on every clock (R2)
  logic exp_rv = 1'b0;
  always @(posedge clk) exp_rv <= rst_n ? lk_valid : 1'b0;
  always @(negedge clk)
    if (rst_n) check(rsp_valid == exp_rv, "R2", "rsp_valid", 64'(rsp_valid), 64'(exp_rv));

  task automatic idle();
    lk_valid = 0; lk_addr = '0; lk_user = 0; lk_write = 0;
    flush_all = 0; glob_en = 0; inv_valid = 0; inv_page = '0;
    fill_valid = 0; fill_big = 0; fill_page = '0; fill_frame = '0;
    fill_user = 0; fill_wr = 0; fill_glob = 0;
  endtask

  task automatic expect_of(logic [31:0] a, bit usr, bit wr, output logic [3:0] o, output logic [31:0] pa);
    int s, l;
    bit pu, pw, den;
    s = find(0, a); l = find(1, a);
    o = 4'b0100; pa = '0;
    if (s >= 0 || l >= 0) begin
      pu = (l >= 0) ? m_u[l] : m_u[s];
      pw = (l >= 0) ? m_w[l] : m_w[s];
      den = (usr && !pu) || (wr && !pw);
      pa = (l >= 0) ? {m_f[l][19:10], a[21:0]} : {m_f[s], a[11:0]};
      o = {!den, 1'b0, den, (s >= 0 && l >= 0)};
    end
  endtask

  task automatic lookup(logic [31:0] a, bit usr, bit wr, string req);
    logic [3:0] eo; logic [31:0] ep;
    expect_of(a, usr, wr, eo, ep);
    @(negedge clk); lk_valid = 1; lk_addr = a; lk_user = usr; lk_write = wr;
    @(negedge clk); lk_valid = 0;
    check({rsp_hit, rsp_miss, rsp_fault, rsp_multi} == eo, req, "hit/miss/fault/multi",
          64'({rsp_hit, rsp_miss, rsp_fault, rsp_multi}), 64'(eo));
    if (eo[3]) check(rsp_paddr == ep, req, "paddr", 64'(rsp_paddr), 64'(ep));
  endtask

  task automatic probe(logic [31:0] a, output bit h);
    @(negedge clk); lk_valid = 1; lk_addr = a; lk_user = 0; lk_write = 0;
    @(negedge clk); lk_valid = 0; h = rsp_hit;
  endtask

  task automatic model_fill(logic [31:0] a, logic [19:0] f, bit big, bit u, bit w, bit g);
    int i;
    i = find(big, a);
    if (i < 0) for (int k = 0; k < 64; k++) if (!m_v[k]) begin i = k; break; end
    m_v[i] = 1; m_big[i] = big; m_a[i] = a; m_f[i] = f; m_u[i] = u; m_w[i] = w; m_g[i] = g;
  endtask

  task automatic fill(logic [31:0] a, logic [19:0] f, bit big, bit u, bit w, bit g);
    @(negedge clk); fill_valid = 1; fill_page = a[31:12]; fill_frame = f;
    fill_big = big; fill_user = u; fill_wr = w; fill_glob = g;
    @(negedge clk); fill_valid = 0;
    model_fill(a, f, big, u, w, g);
  endtask

  task automatic model_inv(logic [31:0] a);
    for (int i = 0; i < 64; i++) if (same(i, 0, a) || same(i, 1, a)) m_v[i] = 0;
  endtask

  task automatic inval(logic [31:0] a);
    @(negedge clk); inv_valid = 1; inv_page = a[31:12];
    @(negedge clk); inv_valid = 0;
    model_inv(a);
  endtask

  task automatic model_flush(bit ge);
    for (int i = 0; i < 64; i++) if (!(ge && m_g[i])) m_v[i] = 0;
  endtask

  task automatic flush(bit ge);
    @(negedge clk); flush_all = 1; glob_en = ge;
    @(negedge clk); flush_all = 0; glob_en = 0;
    model_flush(ge);
  endtask

  // after overflowing a bucket: exactly one older mapping is gone (R9)
  task automatic resolve(logic [31:0] newa, bit big);
    int gone, idx; bit h;
    gone = 0; idx = -1;
    for (int i = 0; i < 64; i++)
      if (bucket(i, big, newa) && !same(i, big, newa)) begin
        probe(m_a[i], h);
        if (!h) begin gone++; idx = i; end
      end
    check(gone == 1, "R9", "evicted count", 64'(gone), 64'd1);
    if (idx >= 0) m_v[idx] = 0;
    lookup(newa, 0, 0, "R9");
  endtask

  localparam logic [31:0] PA = 32'h1234_5678;
  localparam logic [31:0] BG = 32'h4000_0000;

  initial begin
    logic [31:0] a;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi} == 0 && rsp_paddr == 0, "R1",
          "reset outputs", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi}), 64'd0);
    rst_n = 1;
    lookup(PA, 0, 0, "R1");
    lookup(BG, 1, 1, "R1");

    // 4 KB translation
    fill(PA, 20'hABCDE, 0, 1, 1, 0);
    lookup(PA, 1, 1, "R3");
    lookup(PA ^ 32'h0001_0000, 0, 0, "R3");
    lookup(PA ^ 32'h0002_0000, 0, 0, "R3");
    lookup(32'h1234_5FFF, 0, 0, "R3");

    // set fill order and eviction
    for (int k = 0; k < 4; k++) fill((32'(k + 1) << 17) | 32'h3000, 20'h10 + 20'(k), 0, 1, 1, 0);
    for (int k = 0; k < 4; k++) lookup((32'(k + 1) << 17) | 32'h3ABC, 0, 0, "R9");
    a = (32'd5 << 17) | 32'h3000;
    fill(a, 20'h55, 0, 1, 1, 0);
    resolve(a, 0);
    fill(a, 20'h77, 0, 1, 1, 0);
    lookup(a | 32'h123, 0, 0, "R9");

    // 4 MB translation and overlap
    fill(BG, 20'h123FF, 1, 1, 1, 0);
    lookup(32'h4012_3456, 1, 0, "R4");
    lookup(32'h4412_3456, 0, 0, "R4");
    fill(32'h4000_1000, 20'h0BEEF, 0, 1, 1, 0);
    lookup(32'h4000_1ABC, 0, 0, "R5");
    lookup(32'h4000_2ABC, 0, 0, "R5");

    // permissions
    fill(32'h0060_0000, 20'h00600, 0, 0, 1, 0);
    lookup(32'h0060_0010, 1, 0, "R6");
    lookup(32'h0060_0010, 0, 1, "R6");
    fill(32'h0070_0000, 20'h00700, 0, 1, 0, 0);
    lookup(32'h0070_0010, 0, 1, "R6");
    lookup(32'h0070_0010, 1, 0, "R6");
    lookup(32'h0070_0010, 1, 1, "R6");

    // invalidate
    inval(PA);
    lookup(PA, 0, 0, "R8");
    lookup(32'h0060_0000, 0, 0, "R8");
    inval(32'h4000_1000);
    lookup(32'h4000_1ABC, 0, 0, "R8");
    lookup(32'h4000_2ABC, 0, 0, "R8");
    fill(32'h4000_1000, 20'h0BEEF, 0, 1, 1, 1);
    fill(BG, 20'h22200, 1, 1, 1, 1);
    inval(32'h4030_0000);
    lookup(32'h4000_1ABC, 0, 0, "R8");
    lookup(BG, 0, 0, "R8");

    // flush with and without global retention
    fill(BG, 20'h22200, 1, 1, 1, 1);
    fill(32'h0090_0000, 20'h00900, 0, 1, 1, 1);
    flush(1);
    lookup(32'h0090_0004, 0, 0, "R7");
    lookup(BG, 0, 0, "R7");
    lookup(32'h0070_0000, 0, 0, "R7");
    lookup((32'd2 << 17) | 32'h3000, 0, 0, "R7");
    flush(0);
    lookup(32'h0090_0004, 0, 0, "R7");
    lookup(BG, 0, 0, "R7");

    // 4 MB store eviction
    for (int k = 0; k < 4; k++) fill(32'h8000_0000 + (32'(k) << 22), 20'h80000 + (20'(k) << 10), 1, 1, 1, 0);
    for (int k = 0; k < 4; k++) lookup(32'h8000_0004 + (32'(k) << 22), 0, 0, "R9");
    a = 32'h8000_0000 + (32'd4 << 22);
    fill(a, 20'hF0000, 1, 1, 1, 0);
    resolve(a, 1);

    // coinciding operations
    @(negedge clk); flush_all = 1; fill_valid = 1; fill_page = 20'h0A0A0; fill_frame = 20'h1;
    @(negedge clk); idle();
    model_flush(0);
    lookup(32'h0A0A_0000, 0, 0, "R10");
    fill(32'h0B0B_0000, 20'h2, 0, 1, 1, 0);
    @(negedge clk); inv_valid = 1; inv_page = 20'h0C0C0;
    fill_valid = 1; fill_page = 20'h0D0D0; fill_frame = 20'h3; fill_user = 1; fill_wr = 1;
    @(negedge clk); idle();
    lookup(32'h0D0D_0000, 0, 0, "R10");
    lookup(32'h0B0B_0000, 0, 0, "R10");
    @(negedge clk); lk_valid = 1; lk_addr = 32'h0E0E_0000;
    fill_valid = 1; fill_page = 20'h0E0E0; fill_frame = 20'h4; fill_user = 1; fill_wr = 1;
    @(negedge clk); idle();
    check(rsp_miss == 1, "R10", "lookup beside fill", 64'(rsp_miss), 64'd1);
    model_fill(32'h0E0E_0000, 20'h4, 0, 1, 1, 0);
    lookup(32'h0E0E_0000, 0, 0, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule